// File: doc/BRIEF.md
# Charge-Balance Converter Control Sequencer

This block is the digital half of a charge-balancing integrating analog-to-digital converter. Before every eight-clock duty cycle it samples the comparator. It then drives the up/down line that steers the external integrator with one of two fixed patterns. One pattern is mostly low and pulls the integrator down. The other is mostly high and pushes it up. A four-digit sign-magnitude BCD counter follows the up/down line on every counting clock, so over one measurement the count tracks the input charge that the loop had to cancel.

A measurement is a fixed number of duty cycles. An override phase follows it and keeps counting until the auto-zero qualifier, the up/down line and the comparator are all low on the same clock, or until a timeout expires. The sequencer then holds the counter for one clock and copies magnitude, sign and an underrange flag into output latches. It marks the copy with a one-clock strobe, clears the counter and starts again.

Top module: `cb_adc_seq`

## Requirements
- R1: A duty cycle is 8 clocks (slots 0 to 7). In pattern A, `ud_o` is high only in slot 0. In pattern B, `ud_o` is high in slots 0 to 6 and low in slot 7.
- R2: The comparator is sampled in the start clock of a measurement and in slot 7 of every duty cycle. The sample picks the next duty cycle's pattern: high selects A, low selects B.
- R3: On each counting clock the signed count moves by +1 when `ud_o` is high and by −1 when it is low, so a full duty cycle nets −6 for A and +6 for B. The magnitude is kept as four BCD digits, digit 0 in bits 3:0, with carry and borrow across decades, and saturates at 9999.
- R4: When the magnitude is zero and a counting clock occurs, the sign takes the value of `ud_o` (1 = positive) and the magnitude becomes 1.
- R5: After a start clock and MEAS_CYCLES duty cycles the override phase begins. It ends on the first clock on which `muz_i`, `ud_o` and `comp_i` are all low. That clock does not count.
- R6: If the override reaches its OVR_TIMEOUT-th clock without ending, it ends there, and that clock does not count.
- R7: After the override come one hold clock, one load clock and one clear clock, and then the next start clock. `ud_o` is low in all four.
- R8: At the load clock, `res_digits_o`, `res_pos_o` and `underrange_o` (magnitude below UNDER_THRESH) are latched. `load_strobe_o` is high for exactly the following clock, and the latched outputs change at no other time.
- R9: After reset, `ud_o` and `load_strobe_o` are low, `res_digits_o` is zero, `res_pos_o` is 1 and `underrange_o` is 0.
- R10: In a closed loop with an integrator, the latched signed count stays close to input × clocks / step size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| comp_i | input | 1 | Comparator output, high when the integrator is above equilibrium |
| muz_i | input | 1 | Auto-zero qualifier that gates the end of the override |
| ud_o | output | 1 | Up/down drive to the integrator and counter direction |
| res_digits_o | output | 4*NUM_DIGITS | Latched BCD magnitude |
| res_pos_o | output | 1 | Latched polarity, 1 = positive |
| underrange_o | output | 1 | Latched magnitude below threshold |
| load_strobe_o | output | 1 | One-clock pulse when the latches take new values |

## Verification
The bench drives the comparator constantly high and constantly low, with the qualifier held so that the override must time out. These are the runs where an off-by-one in the slot counter, a pattern chosen from a stale sample, or a counted stop clock shifts the latched magnitude away from its closed-form value. Pinned patterns also drive the count through zero. A design that kept the first sign after the zero crossing would latch the wrong polarity, and one with broken decade borrow would show non-BCD digits. Closed-loop runs at positive, zero and negative input check the underrange flag and proportionality. A per-clock reference model catches a strobe that is too wide or latches that move between loads.

// File: rtl/cb_adc_pkg.sv
// Package: shared phase encoding and duty-cycle constants for the
// charge-balance sequencer. Assumes an 8-slot duty cycle throughout.
package cb_adc_pkg;

    localparam int SLOTS_PER_DUTY = 8;
    localparam int SLOT_W         = $clog2(SLOTS_PER_DUTY);

    typedef enum logic [2:0] {
        PH_START    = 3'd0,
        PH_MEASURE  = 3'd1,
        PH_OVERRIDE = 3'd2,
        PH_HOLD     = 3'd3,
        PH_LOAD     = 3'd4,
        PH_CLEAR    = 3'd5
    } phase_e;

endpackage

// File: rtl/cb_duty_gen.sv
// Duty-cycle generator: walks slots 0..7 while counting is active and forms
// the up/down drive from the pattern chosen by the last comparator sample.
// Assumes the sequencer gives one START clock before the first duty cycle.
module cb_duty_gen
    import cb_adc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  logic              comp,
    output logic              ud,
    output logic              duty_last,
    output logic [SLOT_W-1:0] slot,
    output logic              pat_a
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS_PER_DUTY - 1);

    logic run;

    // Purpose: counting phases are the only ones that drive the integrator.
    assign run = (phase == PH_MEASURE) || (phase == PH_OVERRIDE);

    // Purpose: slot counter and pattern choice, sampled before each duty cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot  <= '0;
            pat_a <= 1'b0;
        end else if (phase == PH_START) begin
            slot  <= '0;
            pat_a <= comp;
        end else if (run) begin
            slot <= slot + 1'b1;
            if (slot == LAST_SLOT) begin
                pat_a <= comp;
            end
        end else begin
            slot <= '0;
        end
    end

    // Purpose: pattern A is high only in slot 0; pattern B low only in the last slot.
    always_comb begin
        if (!run) begin
            ud = 1'b0;
        end else if (pat_a) begin
            ud = (slot == '0);
        end else begin
            ud = (slot != LAST_SLOT);
        end
    end

    assign duty_last = run && (slot == LAST_SLOT);

endmodule

// File: rtl/cb_seq_ctrl.sv
// Sequencer: counts measure duty cycles, runs the override until the
// three-way low condition or the timeout, then steps hold, load and clear.
// Assumes MEAS_CYCLES >= 2 and OVR_TIMEOUT >= 2.
module cb_seq_ctrl
    import cb_adc_pkg::*;
#(
    parameter int MEAS_CYCLES = 256,
    parameter int OVR_TIMEOUT = 1024
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   comp,
    input  logic   muz,
    input  logic   ud,
    input  logic   duty_last,
    output phase_e phase,
    output logic   count_en,
    output logic   load_now,
    output logic   clear_now
);

    localparam int DC_W = (MEAS_CYCLES > 1) ? $clog2(MEAS_CYCLES) : 1;
    localparam int OT_W = (OVR_TIMEOUT > 1) ? $clog2(OVR_TIMEOUT) : 1;
    localparam logic [DC_W-1:0] DC_LAST = DC_W'(MEAS_CYCLES - 1);
    localparam logic [OT_W-1:0] OT_LAST = OT_W'(OVR_TIMEOUT - 1);

    logic [DC_W-1:0] dc_q;
    logic [OT_W-1:0] ot_q;
    logic            balanced;
    logic            ovr_stop;

    // Purpose: the override ends on balance or at its last permitted clock.
    assign balanced = !muz && !ud && !comp;
    assign ovr_stop = (phase == PH_OVERRIDE) && (balanced || (ot_q == OT_LAST));

    // Purpose: count on every measure/override clock except the stopping one.
    assign count_en  = ((phase == PH_MEASURE) || (phase == PH_OVERRIDE)) && !ovr_stop;
    assign load_now  = (phase == PH_LOAD);
    assign clear_now = (phase == PH_CLEAR);

    // Purpose: phase transitions plus duty-cycle and timeout counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_START;
            dc_q  <= '0;
            ot_q  <= '0;
        end else begin
            case (phase)
                PH_START: begin
                    phase <= PH_MEASURE;
                    dc_q  <= '0;
                end
                PH_MEASURE: begin
                    if (duty_last) begin
                        if (dc_q == DC_LAST) begin
                            phase <= PH_OVERRIDE;
                            ot_q  <= '0;
                        end else begin
                            dc_q <= dc_q + 1'b1;
                        end
                    end
                end
                PH_OVERRIDE: begin
                    if (ovr_stop) begin
                        phase <= PH_HOLD;
                    end else begin
                        ot_q <= ot_q + 1'b1;
                    end
                end
                PH_HOLD:  phase <= PH_LOAD;
                PH_LOAD:  phase <= PH_CLEAR;
                PH_CLEAR: phase <= PH_START;
                default:  phase <= PH_START;
            endcase
        end
    end

endmodule

// File: rtl/cb_bcd_counter.sv
// Sign-magnitude BCD up/down counter. The magnitude moves away from zero
// when the direction matches the sign and toward zero otherwise. A step
// from zero takes the sign from the direction. Saturates at all nines.
module cb_bcd_counter #(
    parameter int NUM_DIGITS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step_en,
    input  logic                    up,
    input  logic                    clear,
    output logic [NUM_DIGITS*4-1:0] mag,
    output logic                    sign_pos,
    output logic                    mag_zero
);

    localparam int MAG_W = NUM_DIGITS * 4;

    logic [NUM_DIGITS-1:0] is_nine;
    logic [NUM_DIGITS-1:0] is_zero;
    logic [NUM_DIGITS-1:0] inc_hit;
    logic [NUM_DIGITS-1:0] dec_hit;
    logic [MAG_W-1:0]      mag_inc;
    logic [MAG_W-1:0]      mag_dec;
    logic                  all_nine;

    // Purpose: per-digit carry and borrow, each built from lower-digit flags without a chain.
    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
        assign is_nine[i] = (mag[i*4 +: 4] == 4'd9);
        assign is_zero[i] = (mag[i*4 +: 4] == 4'd0);
        if (i == 0) begin : g_lsd
            assign inc_hit[i] = 1'b1;
            assign dec_hit[i] = 1'b1;
        end else begin : g_upper
            assign inc_hit[i] = &is_nine[i-1:0];
            assign dec_hit[i] = &is_zero[i-1:0];
        end
        assign mag_inc[i*4 +: 4] = !inc_hit[i] ? mag[i*4 +: 4] :
                                   (is_nine[i] ? 4'd0 : mag[i*4 +: 4] + 4'd1);
        assign mag_dec[i*4 +: 4] = !dec_hit[i] ? mag[i*4 +: 4] :
                                   (is_zero[i] ? 4'd9 : mag[i*4 +: 4] - 4'd1);
    end

    assign all_nine = &is_nine;
    assign mag_zero = &is_zero;

    // Purpose: apply one signed step, a zero crossing, or a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mag      <= '0;
            sign_pos <= 1'b1;
        end else if (clear) begin
            mag <= '0;
        end else if (step_en) begin
            if (mag_zero) begin
                sign_pos <= up;
                mag      <= MAG_W'(1);
            end else if (up == sign_pos) begin
                if (!all_nine) begin
                    mag <= mag_inc;
                end
            end else begin
                mag <= mag_dec;
            end
        end
    end

endmodule

// File: rtl/cb_result_latch.sv
// Output latches: capture magnitude, sign and the underrange decision when
// told to load, and raise a one-clock strobe. Holds values otherwise.
module cb_result_latch #(
    parameter int NUM_DIGITS   = 4,
    parameter int UNDER_THRESH = 100
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [NUM_DIGITS*4-1:0] mag,
    input  logic                    sign_pos,
    output logic [NUM_DIGITS*4-1:0] res_digits,
    output logic                    res_pos,
    output logic                    underrange,
    output logic                    load_strobe
);

    // Purpose: binary value of a BCD magnitude for the threshold compare.
    function automatic int bcd_value(input logic [NUM_DIGITS*4-1:0] v);
        int acc;
        acc = 0;
        for (int i = NUM_DIGITS - 1; i >= 0; i--) begin
            acc = acc * 10 + 32'(v[i*4 +: 4]);
        end
        return acc;
    endfunction

    logic under_now;

    // Purpose: decide underrange from the live counter at load time.
    assign under_now = (bcd_value(mag) < UNDER_THRESH);

    // Purpose: latch the result and pulse the strobe on a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_digits  <= '0;
            res_pos     <= 1'b1;
            underrange  <= 1'b0;
            load_strobe <= 1'b0;
        end else begin
            load_strobe <= load;
            if (load) begin
                res_digits <= mag;
                res_pos    <= sign_pos;
                underrange <= under_now;
            end
        end
    end

endmodule

// File: rtl/cb_adc_seq.sv
// Top: charge-balance converter control sequencer. Joins the duty-cycle
// generator, phase sequencer, BCD counter and result latches. Assumes the
// comparator and auto-zero qualifier are already synchronous to clk.
module cb_adc_seq
    import cb_adc_pkg::*;
#(
    parameter int NUM_DIGITS   = 4,
    parameter int MEAS_CYCLES  = 256,
    parameter int OVR_TIMEOUT  = 1024,
    parameter int UNDER_THRESH = 100
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    comp_i,
    input  logic                    muz_i,
    output logic                    ud_o,
    output logic [NUM_DIGITS*4-1:0] res_digits_o,
    output logic                    res_pos_o,
    output logic                    underrange_o,
    output logic                    load_strobe_o
);

    phase_e                  phase;
    logic                    duty_last;
    logic [SLOT_W-1:0]       slot;
    logic                    pat_a;
    logic                    count_en;
    logic                    load_now;
    logic                    clear_now;
    logic [NUM_DIGITS*4-1:0] mag;
    logic                    sign_pos;
    logic                    mag_zero;

    cb_duty_gen u_duty (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .comp      (comp_i),
        .ud        (ud_o),
        .duty_last (duty_last),
        .slot      (slot),
        .pat_a     (pat_a)
    );

    cb_seq_ctrl #(
        .MEAS_CYCLES (MEAS_CYCLES),
        .OVR_TIMEOUT (OVR_TIMEOUT)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .comp      (comp_i),
        .muz       (muz_i),
        .ud        (ud_o),
        .duty_last (duty_last),
        .phase     (phase),
        .count_en  (count_en),
        .load_now  (load_now),
        .clear_now (clear_now)
    );

    cb_bcd_counter #(
        .NUM_DIGITS (NUM_DIGITS)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (count_en),
        .up       (ud_o),
        .clear    (clear_now),
        .mag      (mag),
        .sign_pos (sign_pos),
        .mag_zero (mag_zero)
    );

    cb_result_latch #(
        .NUM_DIGITS   (NUM_DIGITS),
        .UNDER_THRESH (UNDER_THRESH)
    ) u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load_now),
        .mag         (mag),
        .sign_pos    (sign_pos),
        .res_digits  (res_digits_o),
        .res_pos     (res_pos_o),
        .underrange  (underrange_o),
        .load_strobe (load_strobe_o)
    );

endmodule

// File: rtl/cb_adc_seq_chk.sv
// Checker: temporal properties of the sequencer, bound into cb_adc_seq.
module cb_adc_seq_chk
    import cb_adc_pkg::*;
#(
    parameter int NUM_DIGITS  = 4,
    parameter int OVR_TIMEOUT = 1024
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    comp_i,
    input logic                    muz_i,
    input logic                    ud_o,
    input logic                    load_strobe_o,
    input logic [NUM_DIGITS*4-1:0] res_digits_o,
    input phase_e                  phase,
    input logic [SLOT_W-1:0]       slot,
    input logic                    pat_a,
    input logic                    count_en,
    input logic                    mag_zero,
    input logic                    sign_pos
);

    logic run;
    int   ovr_seen;

    assign run = (phase == PH_MEASURE) || (phase == PH_OVERRIDE);

    // Purpose: count clocks spent in the override so far.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_seen <= 0;
        end else if (phase == PH_OVERRIDE) begin
            ovr_seen <= ovr_seen + 1;
        end else begin
            ovr_seen <= 0;
        end
    end

    AST_PAT_A_ONE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (run && pat_a && slot != '0) |-> !ud_o); // R1
    AST_PAT_B_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !pat_a && slot != SLOT_W'(SLOTS_PER_DUTY - 1)) |-> ud_o); // R1
    AST_SAMPLE_BEFORE_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        (run && slot == SLOT_W'(SLOTS_PER_DUTY - 1)) |=> (pat_a == $past(comp_i))); // R2
    AST_ZERO_CROSS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && mag_zero) |=> (sign_pos == $past(ud_o))); // R4
    AST_OVR_BALANCE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_OVERRIDE && !muz_i && !ud_o && !comp_i) |=> (phase == PH_HOLD)); // R5
    AST_OVR_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_OVERRIDE) |-> (ovr_seen < OVR_TIMEOUT)); // R6
    AST_IDLE_UD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !ud_o); // R7
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        load_strobe_o |=> !load_strobe_o); // R8
    AST_LATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !load_strobe_o |-> $stable(res_digits_o)); // R8

endmodule

bind cb_adc_seq cb_adc_seq_chk #(
    .NUM_DIGITS  (NUM_DIGITS),
    .OVR_TIMEOUT (OVR_TIMEOUT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .comp_i        (comp_i),
    .muz_i         (muz_i),
    .ud_o          (ud_o),
    .load_strobe_o (load_strobe_o),
    .res_digits_o  (res_digits_o),
    .phase         (phase),
    .slot          (slot),
    .pat_a         (pat_a),
    .count_en      (count_en),
    .mag_zero      (mag_zero),
    .sign_pos      (sign_pos)
);

// File: tb/tb_cb_adc_seq.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock, plus an
// integrator model for closed-loop runs and directed pinned-comparator runs.
module tb_cb_adc_seq;

    localparam int ND   = 4;
    localparam int MEAS = 32;
    localparam int OVR  = 40;
    localparam int UT   = 100;
    localparam int K    = 8;
    localparam int TOL  = 40;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            comp = 1'b0;
    logic            muz = 1'b0;
    logic            ud_o;
    logic [ND*4-1:0] res_digits_o;
    logic            res_pos_o;
    logic            underrange_o;
    logic            load_strobe_o;

    always #10 clk = ~clk;

    cb_adc_seq #(
        .NUM_DIGITS   (ND),
        .MEAS_CYCLES  (MEAS),
        .OVR_TIMEOUT  (OVR),
        .UNDER_THRESH (UT)
    ) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .comp_i        (comp),
        .muz_i         (muz),
        .ud_o          (ud_o),
        .res_digits_o  (res_digits_o),
        .res_pos_o     (res_pos_o),
        .underrange_o  (underrange_o),
        .load_strobe_o (load_strobe_o)
    );

    int n_chk = 0;
    int n_fail = 0;

    // stimulus settings: mode -1 = integrator, 0/1 = pinned comparator
    int mode = 0;
    int vin = 0;
    bit muz_drv = 1'b0;
    int acc = 0;

    // reference model state
    int m_ph = 0, m_slot = 0, m_dc = 0, m_ovr = 0, m_mag = 0;
    bit m_pat = 1'b0, m_pos = 1'b1, m_strobe = 1'b0;
    int r_mag = 0;
    bit r_pos = 1'b1, r_under = 1'b0;
    int n_loads = 0, period_cnt = 0, last_period = 0, last_signed = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int to_bcd(input int m);
        int r = 0;
        int v = m;
        for (int i = 0; i < ND; i++) begin
            r = r | ((v % 10) << (4 * i));
            v = v / 10;
        end
        return r;
    endfunction

    function automatic bit model_ud();
        if (m_ph != 1 && m_ph != 2) return 1'b0;
        if (m_pat) return (m_slot == 0);
        return (m_slot != 7);
    endfunction

    // set inputs for the coming edge, then advance the model across it
    task automatic drive_and_advance();
        bit u, run, stop;
        int old_ph, old_slot;
        u = model_ud();
        acc = acc + (u ? K : -K) - vin;
        comp = (mode < 0) ? (acc > 0) : mode[0];
        muz = muz_drv;
        old_ph = m_ph;
        old_slot = m_slot;
        run = (old_ph == 1 || old_ph == 2);
        stop = (old_ph == 2) && ((!muz && !u && !comp) || (m_ovr == OVR - 1));
        period_cnt++;
        if (run && !stop) begin
            if (m_mag == 0) begin
                m_pos = u;
                m_mag = 1;
            end else if (u == m_pos) begin
                if (m_mag < 9999) m_mag++;
            end else begin
                m_mag--;
            end
        end
        m_strobe = (old_ph == 4);
        if (old_ph == 4) begin
            r_mag = m_mag;
            r_pos = m_pos;
            r_under = (m_mag < UT);
            last_signed = m_pos ? m_mag : -m_mag;
            last_period = period_cnt;
            n_loads++;
        end
        if (old_ph == 0) begin
            m_pat = comp;
            m_slot = 0;
        end else if (run) begin
            if (old_slot == 7) m_pat = comp;
            m_slot = (old_slot + 1) % 8;
        end else begin
            m_slot = 0;
        end
        case (old_ph)
            0: begin m_ph = 1; m_dc = 0; end
            1: if (old_slot == 7) begin
                   if (m_dc == MEAS - 1) begin m_ph = 2; m_ovr = 0; end
                   else m_dc++;
               end
            2: if (stop) m_ph = 3; else m_ovr++;
            3: m_ph = 4;
            4: m_ph = 5;
            default: begin m_ph = 0; m_mag = 0; period_cnt = 0; end
        endcase
    endtask

    // one clock: compare outputs with the model, then drive the next edge
    task automatic tick();
        @(negedge clk);
        check(ud_o == model_ud(), "R1 R2 R7", "ud", int'(ud_o), int'(model_ud()));
        check(load_strobe_o == m_strobe, "R8", "strobe", int'(load_strobe_o), int'(m_strobe));
        check(int'(res_digits_o) == to_bcd(r_mag), "R3 R8", "digits",
              int'(res_digits_o), to_bcd(r_mag));
        check(res_pos_o == r_pos, "R4 R8", "polarity", int'(res_pos_o), int'(r_pos));
        check(underrange_o == r_under, "R8", "underrange", int'(underrange_o), int'(r_under));
        drive_and_advance();
    endtask

    task automatic run_loads(input int k);
        int target = n_loads + k;
        while (n_loads < target) tick();
        tick();
    endtask

    initial begin
        int q = (OVR - 1) / 8;
        int r = (OVR - 1) % 8;
        int exp_b = 6 * MEAS + 6 * q + r;
        int exp_a = 6 * MEAS + 6 * q - ((r != 0) ? (2 - r) : 0);
        int full_period = 1 + 8 * MEAS + OVR + 2;
        int diff;

        // R9: reset state
        mode = 0; muz_drv = 1'b1; vin = 0;
        repeat (3) @(negedge clk);
        check(ud_o == 1'b0, "R9", "reset ud", int'(ud_o), 0);
        check(load_strobe_o == 1'b0, "R9", "reset strobe", int'(load_strobe_o), 0);
        check(res_digits_o == '0, "R9", "reset digits", int'(res_digits_o), 0);
        check(res_pos_o == 1'b1, "R9", "reset polarity", int'(res_pos_o), 1);
        check(underrange_o == 1'b0, "R9", "reset underrange", int'(underrange_o), 0);
        rst_n = 1'b1;
        drive_and_advance();

        // R3 R6: comparator pinned low -> all pattern B, override times out
        run_loads(1);
        check(int'(res_digits_o) == to_bcd(exp_b), "R3", "pinned B magnitude",
              int'(res_digits_o), to_bcd(exp_b));
        check(res_pos_o == 1'b1, "R4", "pinned B polarity", int'(res_pos_o), 1);
        check(last_period == full_period, "R6 R7", "timeout period", last_period, full_period);

        // R3 R4: comparator pinned high -> all pattern A, negative result
        mode = 1; muz_drv = 1'b0;
        run_loads(2);
        check(int'(res_digits_o) == to_bcd(exp_a), "R3", "pinned A magnitude",
              int'(res_digits_o), to_bcd(exp_a));
        check(res_pos_o == 1'b0, "R4", "pinned A polarity", int'(res_pos_o), 0);

        // R10 R8 R5: closed loop at zero input
        mode = -1; vin = 0; acc = 0;
        run_loads(2);
        check(underrange_o == 1'b1, "R8", "zero input underrange", int'(underrange_o), 1);
        check(last_period < full_period, "R5", "balanced override end", last_period, full_period);
        diff = last_signed * K - vin * last_period;
        check(diff <= TOL * K && diff >= -TOL * K, "R10", "zero input count", last_signed, 0);

        // R10 R8: positive input
        vin = 5; acc = 0;
        run_loads(2);
        diff = last_signed * K - vin * last_period;
        check(diff <= TOL * K && diff >= -TOL * K, "R10", "positive count",
              last_signed, vin * last_period / K);
        check(underrange_o == 1'b0, "R8", "positive underrange", int'(underrange_o), 0);
        check(res_pos_o == 1'b1, "R4", "positive polarity", int'(res_pos_o), 1);

        // R10 R4: negative input
        vin = -4; acc = 0;
        run_loads(2);
        diff = last_signed * K - vin * last_period;
        check(diff <= TOL * K && diff >= -TOL * K, "R10", "negative count",
              last_signed, vin * last_period / K);
        check(res_pos_o == 1'b0, "R4", "negative polarity", int'(res_pos_o), 0);

        // R6: qualifier held high in closed loop forces the timeout path
        vin = 2; acc = 0; muz_drv = 1'b1;
        run_loads(2);
        check(last_period == full_period, "R6", "qualifier-held period", last_period, full_period);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule